// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder and Test Data Path

This block is the instruction and data-register side of a boundary-scan test port placed in front of a memory device's pads. A separate test-port sequencer reports its current state as one-cycle indications. This block keeps a 3-bit instruction register and decodes it into one of three serial paths: a 1-bit bypass cell, a 32-bit identification register, or a boundary register. The boundary register has one cell for each input pin and one for each output pin. The block also chooses what reaches the output pads: the functional value from the memory core, a test value held in an update latch, or nothing (high impedance).

Everything runs on the test clock. Capture, shift and update actions take place on the rising edge. TDO is re-timed onto the falling edge, so a downstream device samples it half a period later. Pad outputs come from registers, which makes a change of instruction or of the update latch reach the pins one rising edge later. Instruction codes that no instruction uses fall back to the bypass path and to functional pads, so a wrong code never disturbs the memory.

Top module: `scan_sel`

## Requirements
- R1: A synchronous active-high reset selects the identification instruction and clears the update latch, `pad_out`, `pad_oe`, `hiz` and `tdo` to 0.
- R2: Under the identification instruction (code 001), Capture-DR loads `ID_VALUE` into the 32-bit identification register. Each Shift-DR cycle then presents its bit 0 on `tdo` and shifts `tdi` in at bit 31.
- R3: Capture-IR loads the instruction shift stage with 001, so the first three Shift-IR cycles show 1, 0, 0 on `tdo`. Codes enter at `tdi` least significant bit first. `tdo` changes on the falling edge and is 0 outside Shift-IR and Shift-DR.
- R4: Under the bypass instruction (code 111), the serial path is a single cell that captures 0. Each bit on `tdo` is the `tdi` bit of the previous shift cycle.
- R5: Codes 011, 101 and 110 act exactly like bypass: a one-cell path, with functional pads and `hiz` low.
- R6: Under sample/preload (code 100), Capture-DR loads boundary bits 0..N_IN-1 from `pin_in` and bits N_IN..N_IN+N_OUT-1 from `core_out`. Bit 0 appears on `tdo` first. The pads stay functional.
- R7: The update latch is loaded from the upper N_OUT boundary bits only in an Update-DR cycle while a boundary instruction (000, 010, 100) is active. It holds at every other time, including the shift cycles.
- R8: Under external test (code 000), from the second rising edge after Update-IR, `pad_oe` is all ones and `pad_out` equals the update latch. The input cells capture `pin_in`.
- R9: Under high-impedance sample (code 010), `hiz` is 1 and `pad_oe` is 0 from the second rising edge after Update-IR. The boundary register is the serial path.
- R10: A code shifted into the instruction stage has no effect on pads or path selection until an Update-IR cycle.
- R11: Test-Logic-Reset selects the identification instruction. It wins over an Update-IR indicated in the same cycle.
- R12: Under every instruction except 000 and 010, each rising edge copies `core_out` to `pad_out` and `core_oe` to `pad_oe`, and drives `hiz` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| st_tlr | input | 1 | Sequencer is in Test-Logic-Reset |
| st_capture_ir | input | 1 | Sequencer is in Capture-IR |
| st_shift_ir | input | 1 | Sequencer is in Shift-IR |
| st_update_ir | input | 1 | Sequencer is in Update-IR |
| st_capture_dr | input | 1 | Sequencer is in Capture-DR |
| st_shift_dr | input | 1 | Sequencer is in Shift-DR |
| st_update_dr | input | 1 | Sequencer is in Update-DR |
| tdi | input | 1 | Serial test data in |
| pin_in | input | N_IN | Values seen on the device input pins |
| core_out | input | N_OUT | Functional output values from the memory core |
| core_oe | input | N_OUT | Functional output enables from the memory core |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| pad_out | output | N_OUT | Value driven to each output pad |
| pad_oe | output | N_OUT | Drive enable for each output pad |
| hiz | output | 1 | High when all functional outputs are forced off |

## Verification
Two functions can fall in the same cycle. Test-Logic-Reset can arrive together with an Update-IR that would commit an external-test code. Under external test, the boundary capture also runs while the pads are being driven from the update latch. The bench forces the first case by asserting both indications in one cycle, with `core_oe` held at 0 so that an external-test result (all enables high) is easy to tell apart. It judges the outcome from the pad enables and from an identification readout that follows. For the second case, the bench compares `pad_out` against the modelled latch on every shift cycle, and checks that the captured input bits match `pin_in`.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  // Pattern placed in the instruction shift stage at Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    P_BYP = 2'd0,
    P_ID  = 2'd1,
    P_BSR = 2'd2
  } path_e;

  typedef struct packed {
    path_e path;
    logic  drive_test;
    logic  force_hiz;
  } dec_t;

  function automatic dec_t decode(input logic [IR_W-1:0] code);
    dec_t d;
    d.path       = P_BYP;
    d.drive_test = 1'b0;
    d.force_hiz  = 1'b0;
    case (code)
      OP_EXTEST: begin
        d.path       = P_BSR;
        d.drive_test = 1'b1;
      end
      OP_IDENT:  d.path = P_ID;
      OP_SAMPZ: begin
        d.path      = P_BSR;
        d.force_hiz = 1'b1;
      end
      OP_SAMPLE: d.path = P_BSR;
      default:   d.path = P_BYP;  // bypass and every unused code
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scan_ir.sv
module scan_ir
  import scan_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            cap,
  input  logic            shift,
  input  logic            upd,
  input  logic            tdi,
  output logic            so,
  output logic [IR_W-1:0] code
);

  logic [IR_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || st_tlr) begin
      sh_q <= IR_CAPTURE;
      code <= OP_IDENT;
    end else begin
      if (cap) begin
        sh_q <= IR_CAPTURE;
      end else if (shift) begin
        sh_q <= {tdi, sh_q[IR_W-1:1]};
      end
      if (upd) begin
        code <= sh_q;
      end
    end
  end

  assign so = sh_q[0];

endmodule

// File: rtl/scan_dregs.sv
module scan_dregs
  import scan_sel_pkg::*;
#(
  parameter int          N_IN     = 8,
  parameter int          N_OUT    = 6,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h2B6D_7011
) (
  input  logic             clk,
  input  logic             rst,
  input  path_e            path,
  input  logic             cap,
  input  logic             shift,
  input  logic             upd,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic             so,
  output logic [N_OUT-1:0] upd_q
);

  localparam int BSR_W = N_IN + N_OUT;

  logic             byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE[ID_W-1:0];
      bsr_q <= '0;
      upd_q <= '0;
    end else begin
      case (path)
        P_BYP: begin
          if (cap)        byp_q <= 1'b0;
          else if (shift) byp_q <= tdi;
        end
        P_ID: begin
          if (cap)        id_q <= ID_VALUE[ID_W-1:0];
          else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        default: begin
          if (cap)        bsr_q <= {core_out, pin_in};
          else if (shift) bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
          if (upd)        upd_q <= bsr_q[BSR_W-1:N_IN];
        end
      endcase
    end
  end

  always_comb begin
    case (path)
      P_BYP:   so = byp_q;
      P_ID:    so = id_q[0];
      default: so = bsr_q[0];
    endcase
  end

endmodule

// File: rtl/scan_padctl.sv
module scan_padctl #(
  parameter int N_OUT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drive_test,
  input  logic             force_hiz,
  input  logic [N_OUT-1:0] upd_q,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             hiz
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[g] <= 1'b0;
        pad_oe[g]  <= 1'b0;
      end else if (drive_test) begin
        pad_out[g] <= upd_q[g];
        pad_oe[g]  <= 1'b1;
      end else if (force_hiz) begin
        pad_out[g] <= core_out[g];
        pad_oe[g]  <= 1'b0;
      end else begin
        pad_out[g] <= core_out[g];
        pad_oe[g]  <= core_oe[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hiz <= 1'b0;
    else     hiz <= force_hiz;
  end

endmodule

// File: rtl/scan_sel.sv
module scan_sel
  import scan_sel_pkg::*;
#(
  parameter int          N_IN     = 8,
  parameter int          N_OUT    = 6,
  parameter logic [31:0] ID_VALUE = 32'h2B6D_7011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_tlr,
  input  logic             st_capture_ir,
  input  logic             st_shift_ir,
  input  logic             st_update_ir,
  input  logic             st_capture_dr,
  input  logic             st_shift_dr,
  input  logic             st_update_dr,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic             tdo,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             hiz
);

  logic [IR_W-1:0]  ir_code;
  logic             ir_so;
  logic             dr_so;
  logic [N_OUT-1:0] upd_q;
  dec_t             dec;

  scan_ir u_ir (
    .clk   (clk),
    .rst   (rst),
    .st_tlr(st_tlr),
    .cap   (st_capture_ir),
    .shift (st_shift_ir),
    .upd   (st_update_ir),
    .tdi   (tdi),
    .so    (ir_so),
    .code  (ir_code)
  );

  assign dec = decode(ir_code);

  scan_dregs #(
    .N_IN    (N_IN),
    .N_OUT   (N_OUT),
    .ID_W    (32),
    .ID_VALUE(ID_VALUE)
  ) u_dr (
    .clk     (clk),
    .rst     (rst),
    .path    (dec.path),
    .cap     (st_capture_dr),
    .shift   (st_shift_dr),
    .upd     (st_update_dr),
    .tdi     (tdi),
    .pin_in  (pin_in),
    .core_out(core_out),
    .so      (dr_so),
    .upd_q   (upd_q)
  );

  scan_padctl #(.N_OUT(N_OUT)) u_pad (
    .clk       (clk),
    .rst       (rst),
    .drive_test(dec.drive_test),
    .force_hiz (dec.force_hiz),
    .upd_q     (upd_q),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .hiz       (hiz)
  );

  // Serial output re-timed to the falling edge of the test clock
  always_ff @(negedge clk) begin
    if (rst)              tdo <= 1'b0;
    else if (st_shift_ir) tdo <= ir_so;
    else if (st_shift_dr) tdo <= dr_so;
    else                  tdo <= 1'b0;
  end

endmodule

// File: rtl/scan_sel_chk.sv
module scan_sel_chk #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             st_tlr,
  input logic             st_update_ir,
  input logic             st_update_dr,
  input logic [2:0]       ir_code,
  input logic [N_OUT-1:0] upd_q,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] core_oe,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe,
  input logic             hiz
);

  logic [N_IN-1:0] unused_width;
  assign unused_width = '0;

  // R10
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_update_ir && !st_tlr) |=> $stable(ir_code));

  // R11
  tlr_ident_chk: assert property (@(posedge clk) disable iff (rst)
    st_tlr |=> (ir_code == 3'b001));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_update_dr |=> $stable(upd_q));

  // R8
  extest_pads_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_code == 3'b000) |=> ((pad_oe == {N_OUT{1'b1}}) && (pad_out == $past(upd_q)) && !hiz));

  // R9
  sampz_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_code == 3'b010) |=> (hiz && (pad_oe == '0)));

  // R12
  func_pads_chk: assert property (@(posedge clk) disable iff (rst)
    ((ir_code != 3'b000) && (ir_code != 3'b010)) |=>
      ((pad_out == $past(core_out)) && (pad_oe == $past(core_oe)) && !hiz));

endmodule

bind scan_sel scan_sel_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_tlr      (st_tlr),
  .st_update_ir(st_update_ir),
  .st_update_dr(st_update_dr),
  .ir_code     (ir_code),
  .upd_q       (upd_q),
  .core_out    (core_out),
  .core_oe     (core_oe),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .hiz         (hiz)
);

// File: tb/scan_sel_bench.sv
`timescale 1ns/100ps
module scan_sel_bench;

  localparam int          N_IN  = 8;
  localparam int          N_OUT = 6;
  localparam int          L     = N_IN + N_OUT;
  localparam logic [31:0] ID    = 32'h2B6D_7011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_tlr = 0, st_capture_ir = 0, st_shift_ir = 0, st_update_ir = 0;
  logic st_capture_dr = 0, st_shift_dr = 0, st_update_dr = 0;
  logic tdi = 0;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_OUT-1:0] core_out = '0;
  logic [N_OUT-1:0] core_oe = '0;
  logic tdo;
  logic [N_OUT-1:0] pad_out, pad_oe;
  logic hiz;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [2:0]       cur_code = 3'b001;
  logic [N_OUT-1:0] m_upd = '0;

  always #2 clk = ~clk;

  scan_sel #(.N_IN(N_IN), .N_OUT(N_OUT), .ID_VALUE(ID)) u_scan_sel (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int path_of(input logic [2:0] c);
    if (c == 3'b001) return 1;
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 2;
    return 0;
  endfunction

  function automatic logic [N_OUT-1:0] exp_out();
    return (cur_code == 3'b000) ? m_upd : core_out;
  endfunction

  function automatic logic [N_OUT-1:0] exp_oe();
    if (cur_code == 3'b000) return '1;
    if (cur_code == 3'b010) return '0;
    return core_oe;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_pads(input string tag);
    chk({tag, " pad_out"}, 64'(pad_out), 64'(exp_out()));
    chk({tag, " pad_oe"},  64'(pad_oe),  64'(exp_oe()));
    chk({tag, " hiz"},     64'(hiz),     64'(cur_code == 3'b010));
  endtask

  // R3: captured pattern 1,0,0 leaves first; code enters LSB first
  task automatic do_ir(input logic [2:0] code, input bit commit);
    st_capture_ir = 1; step(); st_capture_ir = 0;
    for (int i = 0; i < 3; i++) begin
      st_shift_ir = 1; tdi = code[i];
      @(negedge clk); #0.5;
      chk("R3 ir capture bit", 64'(tdo), 64'(i == 0));
      step();
    end
    st_shift_ir = 0;
    if (commit) begin
      st_update_ir = 1; step(); st_update_ir = 0;
      cur_code = code;
    end
  endtask

  // R7: pads checked on every shift cycle
  task automatic do_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    st_capture_dr = 1; step(); st_capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      st_shift_dr = 1; tdi = din[i];
      @(negedge clk); #0.5;
      dout[i] = tdo;
      chk("R7 pads stable in shift", 64'(pad_out), 64'(exp_out()));
      step();
    end
    st_shift_dr = 0;
    st_update_dr = 1; step(); st_update_dr = 0;
    if (path_of(cur_code) == 2 && n == L) m_upd = din[L-1:N_IN];
  endtask

  task automatic check_chain(input string tag);
    logic [63:0] din, dout, exp;
    din = {$urandom, $urandom};
    case (path_of(cur_code))
      0: begin
        do_dr(8, din, dout);
        exp = {56'd0, din[6:0], 1'b0};
        chk({tag, " bypass chain"}, dout, exp);
      end
      1: begin
        do_dr(32, din, dout);
        chk({tag, " ident chain"}, dout, 64'(ID));
      end
      default: begin
        exp = 64'({core_out, pin_in});
        do_dr(L, din, dout);
        chk({tag, " boundary chain"}, dout, exp);
      end
    endcase
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic [63:0] pre;
    void'($urandom(32'd2468));
    step(); step(); step();
    @(negedge clk); #0.5;
    chk("R1 reset tdo", 64'(tdo), 64'd0);
    chk("R1 reset pad_out", 64'(pad_out), 64'd0);
    chk("R1 reset pad_oe", 64'(pad_oe), 64'd0);
    chk("R1 reset hiz", 64'(hiz), 64'd0);
    step();
    rst = 0;
    core_out = 6'h2D; core_oe = 6'h33; pin_in = 8'hA6;
    step(); step();
    check_pads("R12 after reset");
    chk("R3 idle tdo", 64'(tdo), 64'd0);
    check_chain("R2 default ident");

    // R4 bypass
    do_ir(3'b111, 1); step(); step();
    check_chain("R4");
    check_pads("R12 bypass");

    // R5 unused codes
    foreach (pre[k]) if (k < 3) begin
      logic [2:0] c;
      c = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
      do_ir(c, 1); step(); step();
      check_chain("R5");
      check_pads("R5 pads functional");
    end

    // R6 sample/preload with a preload of a known pattern
    core_out = 6'h19; pin_in = 8'h5C; core_oe = 6'h0F;
    do_ir(3'b100, 1); step(); step();
    check_pads("R6 pads functional");
    pre = 64'h0000_0000_0000_2ACE;
    do_dr(L, pre, dout);
    chk("R6 sample capture", dout, 64'({core_out, pin_in}));
    step(); step();
    check_pads("R6 after update");

    // R10 shifted code not yet active
    do_ir(3'b000, 0); step(); step();
    check_pads("R10 pending code");
    st_update_ir = 1; step(); st_update_ir = 0;
    cur_code = 3'b000;
    step(); step();
    chk("R8 extest preload value", 64'(pad_out), 64'(pre[L-1:N_IN]));
    check_pads("R8 extest");
    pin_in = 8'hE1;
    check_chain("R8 input capture");
    step(); step();
    check_pads("R8 new latch");

    // R9 high-impedance sample
    do_ir(3'b010, 1); step(); step();
    check_pads("R9");
    check_chain("R9");

    // R11 reset state beats update in the same cycle
    core_oe = '0;
    do_ir(3'b000, 0);
    st_tlr = 1; st_update_ir = 1; step(); st_tlr = 0; st_update_ir = 0;
    cur_code = 3'b001;
    step(); step();
    check_pads("R11 tlr wins");
    check_chain("R11");

    // R11 plain reset state from extest
    do_ir(3'b000, 1);
    st_tlr = 1; step(); st_tlr = 0;
    cur_code = 3'b001;
    step(); step();
    check_pads("R11 tlr");

    // random mix
    for (int k = 0; k < 40; k++) begin
      pin_in = N_IN'($urandom); core_out = N_OUT'($urandom); core_oe = N_OUT'($urandom);
      do_ir(3'($urandom), 1); step(); step();
      check_pads("R12 random pads");
      check_chain("R2 random chain");
      step(); step();
      check_pads("R8 random pads after update");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule